// File: doc/BRIEF.md
# Triple-Redundant Self-Scrubbing Configuration Register Bank

This block holds the configuration of a larger chip: 93 registers, each eight bits wide, with every bit kept in three independent flip-flops. Each register's value, as seen by the rest of the logic and by the read port, is the bitwise majority of its three copies. On every clock edge, each copy that does not agree with the majority is reloaded with the majority value. A single upset in any copy is therefore repaired one cycle later, without any write from the host.

A serial management bus slave drives a plain synchronous port made of an address, write data and a write enable. Read data comes back one cycle after the address is presented. All registers are also presented at once on a flat bus for the datapath. A sticky flag records that a repair has happened, and a clear input resets it. The storage cell that stores, votes and repairs is a standalone parameterised module, so it can also hold state machine state. In this block it also holds the read-data register and the repair flag.

For verification, an upset-injection port flips a single chosen copy of a single chosen bit on a clock edge.

Top module: `tmr_regbank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads all three copies of every register with 0x00, clears `rd_data` to 0x00 and clears `err_flag`.
- R2: With `wr_en` high and `addr` in 0..92, the rising edge loads `wr_data` into all three copies of that register. The new value appears on `cfg_flat` bits [addr*8+7 : addr*8] after that edge.
- R3: A write to an address in 93..255 changes no register: `cfg_flat` is unchanged.
- R4: A read from an address in 93..255 returns 0x00 on `rd_data`.
- R5: `rd_data` is registered. After a rising edge it holds the voted value of the register addressed during the cycle before that edge, taken before any write on the same edge lands. It does not follow `addr` between edges.
- R6: A single flipped copy of a bit does not change the voted value on `cfg_flat` or `rd_data`.
- R7: A copy that disagrees with the majority is rewritten with the majority value on the next rising edge. Consequently, upsets injected into two different copies of the same bit on consecutive edges never change the voted value.
- R8: `err_flag` goes high on the rising edge that ends any cycle in which some copy disagrees, and it stays high until it is cleared.
- R9: `err_clr` high clears `err_flag` at the next edge. If a disagreement is present in that same cycle, setting wins and the flag stays high.
- R10: With `inj_en` high, the edge XORs bit `inj_bit` of copy `inj_copy` of register `inj_addr`. Copy codes 0, 1 and 2 select a copy; code 3, or an `inj_addr` in 93..255, has no effect.
- R11: A write on the same edge as a pending repair loads the new value into all three copies. No disagreement remains afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Register address for read and write |
| wr_data | input | 8 | Data to be written |
| rd_data | output | 8 | Registered voted read data |
| cfg_flat | output | 744 | Voted contents of all registers, register n at bits [8n+7:8n] |
| err_clr | input | 1 | Clears the sticky repair flag |
| err_flag | output | 1 | Sticky flag: a copy disagreement was seen and repaired |
| inj_en | input | 1 | Upset injection enable |
| inj_addr | input | 8 | Register targeted by the injection |
| inj_copy | input | 2 | Copy targeted: 0, 1, 2; 3 means none |
| inj_bit | input | 3 | Bit position targeted by the injection |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. A write appears on `cfg_flat` after the edge that samples it, and a read address gives `rd_data` after the next edge. An injected flip is repaired, and `err_flag` is raised, on the edge that follows the injection edge. The bench changes inputs on falling edges and samples one falling edge later, so each check falls in the half cycle after the edge that should have produced the result. The one deliberate mid-cycle sample checks that `rd_data` has not yet moved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Copy selector used by the upset-injection port.
    typedef enum logic [1:0] {
        COPY_0    = 2'd0,
        COPY_1    = 2'd1,
        COPY_2    = 2'd2,
        COPY_NONE = 2'd3
    } copy_sel_t;

    localparam int unsigned NUM_COPIES = 3;

endpackage

// File: rtl/tmr_maj.sv
module tmr_maj #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] maj,
    output logic [W-1:0] dis
);

    // Bitwise two-out-of-three vote and per-bit disagreement.
    always_comb begin
        maj = (a & b) | (b & c) | (a & c);
        dis = (a ^ b) | (b ^ c);
    end

endmodule

// File: rtl/tmr_cell.sv
module tmr_cell #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] flip0,
    input  logic [W-1:0] flip1,
    input  logic [W-1:0] flip2,
    output logic [W-1:0] voted,
    output logic         mismatch
);

    typedef struct packed {
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        logic [W-1:0] c2;
    } trip_t;

    trip_t        st_q, st_d;
    logic [W-1:0] dis;
    logic [W-1:0] base_d;

    tmr_maj #(.W(W)) u_maj (
        .a   (st_q.c0),
        .b   (st_q.c1),
        .c   (st_q.c2),
        .maj (voted),
        .dis (dis)
    );

    assign mismatch = |dis;

    // Next value: a load overrides; otherwise every copy is rewritten with
    // the vote, which scrubs any disagreeing copy. Injection flips act last.
    always_comb begin
        base_d  = load_en ? load_val : voted;
        st_d.c0 = base_d ^ flip0;
        st_d.c1 = base_d ^ flip1;
        st_d.c2 = base_d ^ flip2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= {RST_VAL, RST_VAL, RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: without injected flips, all copies agree after the next edge.
    assert_scrub_R7: assert property (@(posedge clk) disable iff (rst)
        ((flip0 | flip1 | flip2) == '0) |=> (st_q.c0 == st_q.c1 && st_q.c1 == st_q.c2));

    // R6: a single flipped copy per bit on a clean cell leaves the vote unchanged.
    assert_vote_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !mismatch && (((flip0 & flip1) | (flip1 & flip2) | (flip0 & flip2)) == '0))
        |=> $stable(voted));

    // R2 / R11: a load without flips is seen on the vote after the edge.
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (load_en && ((flip0 | flip1 | flip2) == '0)) |=> (voted == $past(load_val)));

endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 93,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned BIT_W   = $clog2(DATA_W),
    localparam int unsigned FLAT_W  = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAT_W-1:0] cfg_flat,
    input  logic              err_clr,
    output logic              err_flag,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [1:0]        inj_copy,
    input  logic [BIT_W-1:0]  inj_bit
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [DATA_W-1:0] reg_val [NUM_REGS];
    logic [NUM_REGS-1:0] reg_mis;
    logic [DATA_W-1:0] inj_mask;
    logic              any_mis;

    assign inj_mask = DATA_W'(1) << inj_bit;

    // Storage array: one voting cell per register.
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic hit_wr, hit_inj;
            logic [DATA_W-1:0] f0, f1, f2;

            assign hit_wr  = wr_en  && (addr     == ADDR_W'(i));
            assign hit_inj = inj_en && (inj_addr == ADDR_W'(i));
            assign f0 = (hit_inj && inj_copy == COPY_0) ? inj_mask : '0;
            assign f1 = (hit_inj && inj_copy == COPY_1) ? inj_mask : '0;
            assign f2 = (hit_inj && inj_copy == COPY_2) ? inj_mask : '0;

            tmr_cell #(.W(DATA_W), .RST_VAL('0)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .load_en  (hit_wr),
                .load_val (wr_data),
                .flip0    (f0),
                .flip1    (f1),
                .flip2    (f2),
                .voted    (reg_val[i]),
                .mismatch (reg_mis[i])
            );

            assign cfg_flat[i*DATA_W +: DATA_W] = reg_val[i];
        end
    endgenerate

    assign any_mis = |reg_mis;

    // Control state (read register, repair flag), itself held in voting cells.
    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d.rd = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                ctl_d.rd = reg_val[i];
            end
        end
        ctl_d.err = any_mis | (ctl_q.err & ~err_clr);
    end

    logic rd_mis, err_mis;

    tmr_cell #(.W(DATA_W), .RST_VAL('0)) u_rd_cell (
        .clk      (clk),
        .rst      (rst),
        .load_en  (1'b1),
        .load_val (ctl_d.rd),
        .flip0    ('0),
        .flip1    ('0),
        .flip2    ('0),
        .voted    (ctl_q.rd),
        .mismatch (rd_mis)
    );

    tmr_cell #(.W(1), .RST_VAL(1'b0)) u_err_cell (
        .clk      (clk),
        .rst      (rst),
        .load_en  (1'b1),
        .load_val (ctl_d.err),
        .flip0    (1'b0),
        .flip1    (1'b0),
        .flip2    (1'b0),
        .voted    (ctl_q.err),
        .mismatch (err_mis)
    );

    assign rd_data  = ctl_q.rd;
    assign err_flag = ctl_q.err;

    // R1: reset clears everything visible.
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cfg_flat == '0 && rd_data == '0 && !err_flag));

    // R4: out-of-range reads return zero.
    assert_oob_read_R4: assert property (@(posedge clk) disable iff (rst)
        (addr > LAST_ADDR) |=> (rd_data == '0));

    // R3: an out-of-range write with no injection leaves the bank unchanged.
    assert_oob_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > LAST_ADDR && !inj_en) |=> $stable(cfg_flat));

    // R8: any disagreement raises the flag at the next edge.
    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        any_mis |=> err_flag);

    // R9: a clear with nothing to repair drops the flag.
    assert_err_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !any_mis) |=> !err_flag);

endmodule

// File: tb/tb_tmr_regbank.sv
`timescale 1ns/1ps
module tb_tmr_regbank;

    localparam int NREG = 93;
    localparam int FW   = NREG * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [FW-1:0] cfg_flat;
    logic          err_clr = 1'b0;
    logic          err_flag;
    logic          inj_en = 1'b0;
    logic [7:0]    inj_addr = '0;
    logic [1:0]    inj_copy = '0;
    logic [2:0]    inj_bit = '0;

    int checks = 0;
    int errors = 0;
    logic [FW-1:0] shadow = '0;

    always #2 clk = ~clk;

    tmr_regbank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_flat(cfg_flat), .err_clr(err_clr), .err_flag(err_flag),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_copy(inj_copy), .inj_bit(inj_bit)
    );

    // Stimulus table: {address, write data, expected read-back}.
    localparam logic [23:0] VEC [10] = '{
        {8'd0,   8'h11, 8'h11},
        {8'd1,   8'h22, 8'h22},
        {8'd92,  8'hFF, 8'hFF},
        {8'd46,  8'h80, 8'h80},
        {8'd93,  8'h77, 8'h00},
        {8'd255, 8'hAA, 8'h00},
        {8'd0,   8'h5A, 8'h5A},
        {8'd200, 8'h01, 8'h00},
        {8'd7,   8'h00, 8'h00},
        {8'd92,  8'h3C, 8'h3C}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_cfg(string req);
        checks++;
        if (cfg_flat !== shadow) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, cfg_flat, shadow);
        end
    endtask

    function automatic logic [7:0] reg_of(int a);
        return cfg_flat[a*8 +: 8];
    endfunction

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        if (a < NREG) shadow[a*8 +: 8] = d;
    endtask

    task automatic do_read(logic [7:0] a);
        addr = a;
        step();
    endtask

    task automatic inject(logic [7:0] a, logic [2:0] b, logic [1:0] c);
        inj_en = 1'b1; inj_addr = a; inj_bit = b; inj_copy = c;
        step();
        inj_en = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        // R1: reset state
        chk_cfg("R1");
        chk("R1", rd_data, 8'h00);
        chk("R1", err_flag, 0);

        // Table walk: R2 writes, R3 ignored writes, R4 zero reads
        for (int i = 0; i < 10; i++) begin
            do_write(VEC[i][23:16], VEC[i][15:8]);
            chk_cfg("R2 R3");
            do_read(VEC[i][23:16]);
            chk("R2 R4", rd_data, VEC[i][7:0]);
        end

        // R5: rd_data registered, does not follow addr mid-cycle
        do_read(8'd0);
        chk("R5", rd_data, 8'h5A);
        addr = 8'd1;
        #1;
        chk("R5", rd_data, 8'h5A);
        step();
        chk("R5", rd_data, 8'h22);
        // R5: read on the same edge as a write returns the old value
        wr_en = 1'b1; addr = 8'd1; wr_data = 8'h99;
        step();
        wr_en = 1'b0; shadow[8 +: 8] = 8'h99;
        chk("R5", rd_data, 8'h22);
        step();
        chk("R5", rd_data, 8'h99);

        // R6 / R7 / R8: scrubbing of register 10
        do_write(8'd10, 8'hA5);
        clear_err();
        chk("R9", err_flag, 0);
        inject(8'd10, 3'd0, 2'd1);
        chk("R6", reg_of(10), 8'hA5);
        chk("R8", err_flag, 0);
        inject(8'd10, 3'd0, 2'd2);
        chk("R7", reg_of(10), 8'hA5);
        chk("R8", err_flag, 1);
        step();
        chk("R7", reg_of(10), 8'hA5);
        chk("R8", err_flag, 1);
        do_read(8'd10);
        chk("R6", rd_data, 8'hA5);
        clear_err();
        chk("R9", err_flag, 0);

        // R9: set wins over clear
        inject(8'd10, 3'd7, 2'd0);
        err_clr = 1'b1;
        step();
        chk("R9", err_flag, 1);
        step();
        err_clr = 1'b0;
        chk("R9", err_flag, 0);
        chk("R7", reg_of(10), 8'hA5);

        // R10: copy code 3 and out-of-range target have no effect
        inject(8'd10, 3'd3, 2'd3);
        step();
        chk("R10", err_flag, 0);
        inject(8'd100, 3'd3, 2'd0);
        step();
        chk("R10", err_flag, 0);
        chk_cfg("R10");

        // R11: write on top of a pending repair
        inject(8'd20, 3'd1, 2'd0);
        do_write(8'd20, 8'h3C);
        chk("R11", reg_of(20), 8'h3C);
        clear_err();
        chk("R11", err_flag, 0);
        step();
        chk("R11", err_flag, 0);
        chk_cfg("R11");

        // R1: reset after activity
        rst = 1'b1;
        step();
        rst = 1'b0;
        shadow = '0;
        chk_cfg("R1");
        chk("R1", rd_data, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule